// File: doc/BRIEF.md
# One-time polynomial MAC engine

This block produces a 128-bit authenticator over a message of any length. The message is supplied as a series of 128-bit blocks, each with a count of how many of its bytes are valid. A 256-bit one-time key is loaded first. The lower 128 bits become the multiplier r, with fixed bits cleared. The upper 128 bits become the final addend s. Every accepted block is turned into a 129-bit number by appending a single marker byte. That number is added to a running accumulator, and the sum is multiplied by r modulo the prime 2^130−5. When the caller signals the end of the message, the engine fully reduces the accumulator, adds s, keeps the low 128 bits and raises a ready flag.

The multiply is spread over several cycles. A bank of word-wide multiply-accumulate lanes, one lane per word of r, consumes one word of the sum in each cycle. Two fold cycles follow, and in each one the bits at and above bit 130 are multiplied by 5 and added back in. While the engine is in this sequence it shows busy, and any block or end strobe that arrives then is dropped. The caller waits for busy to fall before presenting more work. Splitting a message into blocks, and any length framing, belong to the caller.

Top module: `otmac_engine`

## Requirements
- R1: After reset, ready_o and busy_o are 0 and tag_o is zero.
- R2: A cycle with init_i high loads r from key_i[127:0] and s from key_i[255:128], sets the accumulator to zero, clears tag_o and drops ready_o. Every other strobe in that cycle is ignored.
- R3: r is used only after the AND mask 0x0ffffffc0ffffffc0ffffffc0fffffff is applied, so key bits outside the mask have no effect on the tag.
- R4: A block uses n = min(len_i, 16) bytes. Byte i of the block is blk_i[8i+7:8i]. The value folded in keeps bytes 0..n−1, sets byte n to 0x01 (bit 128 when n is 16) and makes every other byte zero, so block bytes at positions n and above have no effect.
- R5: next_i in an idle cycle starts the update acc = (acc + block)·r mod 2^130−5. busy_o is high for exactly 7 cycles starting with the cycle after the strobe: 5 multiply cycles with the default 32-bit lanes, then 2 fold cycles.
- R6: next_i and finish_i are ignored while busy_o is high.
- R7: finish_i in an idle cycle, with no next_i, sets ready_o one cycle later. tag_o is then (acc mod 2^130−5 + s) mod 2^128.
- R8: An accepted next_i, or init_i, clears ready_o. While ready_o stays high and neither init_i nor next_i arrives, tag_o holds its value.
- R9: An accumulator that is still at or above 2^130−5 at the end receives a final subtraction of 2^130−5 before s is added.
- R10: init_i takes effect in any state, including during a multiply. The cycle after it, busy_o is low, and the next message uses only the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| init_i | input | 1 | Load key and start a new message |
| next_i | input | 1 | Fold in the block on blk_i |
| finish_i | input | 1 | Produce the tag from the accumulator |
| key_i | input | 256 | One-time key: r in the low half, s in the high half |
| blk_i | input | 128 | Message block, little-endian bytes |
| len_i | input | 5 | Valid byte count of blk_i |
| tag_o | output | 128 | Authenticator |
| ready_o | output | 1 | tag_o is valid |
| busy_o | output | 1 | Block update in progress; strobes are dropped |

## Verification
The bench sweeps the block length over every value from 1 to 16, plus an oversize value. It also repeats a length with garbage in the unused bytes, and the tags should not move. A padding marker put in the wrong byte, or unused bytes left in the sum, would change those tags. Two accumulator cases are worked out by hand. A zero multiplier, which also tests the clamp, must give exactly s. A pair of all-ones blocks with r = 1 leaves the accumulator at 2^130−2 and must yield s + 3; a design without the final subtraction would give the wrong value there. Strobes that arrive in the middle of a multiply, and an init that aborts a running update, must leave the tag equal to the reference. A design that accepted those strobes, or that kept the old accumulator after the abort, would produce a different tag.

// File: rtl/otmac_pkg.sv
package otmac_pkg;
   localparam int ACC_W  = 131;   // partially reduced accumulator
   localparam int SUM_W  = 132;   // accumulator plus padded block
   localparam int BLK_W  = 128;
   localparam int PAD_W  = 129;
   localparam logic [BLK_W-1:0] R_MASK = 128'h0ffffffc_0ffffffc_0ffffffc_0fffffff;
   localparam logic [ACC_W-1:0] PRIME  = (131'd1 << 130) - 131'd5;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MUL   = 2'd1,
      ST_FOLD1 = 2'd2,
      ST_FOLD2 = 2'd3
   } otmac_state_e;
endpackage

// File: rtl/otmac_blkprep.sv
module otmac_blkprep
   import otmac_pkg::*;
(
   input  logic [BLK_W-1:0] blk_i,
   input  logic [4:0]       len_i,
   output logic [PAD_W-1:0] m_o
);
   logic [4:0] n_bytes;
   assign n_bytes = (len_i > 5'd16) ? 5'd16 : len_i;

   for (genvar i = 0; i < 16; i++) begin : g_byte
      assign m_o[8*i +: 8] = (5'(i) < n_bytes) ? blk_i[8*i +: 8] :
                             ((5'(i) == n_bytes) ? 8'h01 : 8'h00);
   end
   assign m_o[128] = (n_bytes == 5'd16);
endmodule

// File: rtl/otmac_lanes.sv
module otmac_lanes
   import otmac_pkg::*;
#(
   parameter int WORD_W = 32,
   localparam int LANES = BLK_W / WORD_W,
   localparam int OUT_W = WORD_W + BLK_W
)(
   input  logic [WORD_W-1:0] a_i,
   input  logic [BLK_W-1:0]  r_i,
   output logic [OUT_W-1:0]  sum_o
);
   logic [LANES-1:0][2*WORD_W-1:0] lane_p;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign lane_p[j] = (2*WORD_W)'(a_i) * (2*WORD_W)'(r_i[j*WORD_W +: WORD_W]);
   end

   always_comb begin
      sum_o = '0;
      for (int j = 0; j < LANES; j++) begin
         sum_o = sum_o + (OUT_W'(lane_p[j]) << (j*WORD_W));
      end
   end
endmodule

// File: rtl/otmac_fold.sv
module otmac_fold
   import otmac_pkg::*;
#(
   parameter int IN_W = 256,
   localparam int HI_W = IN_W - 130,
   localparam int HI5_W = HI_W + 3
)(
   input  logic [IN_W-1:0]  x_i,
   output logic [ACC_W-1:0] y_o
);
   logic [HI_W-1:0]  hi;
   logic [HI5_W-1:0] hi5;
   assign hi  = x_i[IN_W-1:130];
   assign hi5 = {hi, 2'b00} + HI5_W'(hi);   // hi * 5, since 2^130 = 5 mod p
   assign y_o = ACC_W'(x_i[129:0]) + ACC_W'(hi5);
endmodule

// File: rtl/otmac_engine.sv
module otmac_engine
   import otmac_pkg::*;
#(
   parameter int WORD_W = 32
)(
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         init_i,
   input  logic         next_i,
   input  logic         finish_i,
   input  logic [255:0] key_i,
   input  logic [127:0] blk_i,
   input  logic [4:0]   len_i,
   output logic [127:0] tag_o,
   output logic         ready_o,
   output logic         busy_o
);
   localparam int SUM_WORDS = (SUM_W + WORD_W - 1) / WORD_W;
   localparam int SUM_PAD   = SUM_WORDS * WORD_W;
   localparam int LANE_W    = WORD_W + BLK_W;
   localparam int PROD_W    = SUM_PAD + BLK_W;
   localparam int CNT_W     = $clog2(SUM_WORDS);
   localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(SUM_WORDS - 1);

   if ((BLK_W % WORD_W) != 0 || WORD_W < 8 || SUM_WORDS < 2) begin : g_bad_word
      $error("otmac_engine: WORD_W must divide 128 and be at least 8");
   end

   otmac_state_e       st_q;
   logic [BLK_W-1:0]   r_q, s_q;
   logic [ACC_W-1:0]   h_q;
   logic [SUM_PAD-1:0] sum_q;
   logic [PROD_W-1:0]  prod_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [127:0]       tag_q;
   logic               ready_q;

   logic [PAD_W-1:0]   m_pad;
   logic [WORD_W-1:0]  lane_a;
   logic [LANE_W-1:0]  lane_sum;
   logic [ACC_W-1:0]   fold_y, fin_f, fin_r;
   logic [127:0]       tag_d;

   otmac_blkprep u_prep (.blk_i(blk_i), .len_i(len_i), .m_o(m_pad));

   assign lane_a = sum_q[cnt_q*WORD_W +: WORD_W];
   otmac_lanes #(.WORD_W(WORD_W)) u_lanes (.a_i(lane_a), .r_i(r_q), .sum_o(lane_sum));

   otmac_fold #(.IN_W(PROD_W)) u_fold_acc (.x_i(prod_q), .y_o(fold_y));
   otmac_fold #(.IN_W(ACC_W))  u_fold_fin (.x_i(h_q),    .y_o(fin_f));

   assign fin_r = (fin_f >= PRIME) ? (fin_f - PRIME) : fin_f;
   assign tag_d = 128'(fin_r + {3'b000, s_q});

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q    <= ST_IDLE;
         r_q     <= '0;
         s_q     <= '0;
         h_q     <= '0;
         sum_q   <= '0;
         prod_q  <= '0;
         cnt_q   <= '0;
         tag_q   <= '0;
         ready_q <= 1'b0;
      end else if (init_i) begin
         st_q    <= ST_IDLE;
         r_q     <= key_i[127:0] & R_MASK;
         s_q     <= key_i[255:128];
         h_q     <= '0;
         tag_q   <= '0;
         ready_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (next_i) begin
                  sum_q   <= SUM_PAD'(h_q) + SUM_PAD'(m_pad);
                  prod_q  <= '0;
                  cnt_q   <= '0;
                  ready_q <= 1'b0;
                  st_q    <= ST_MUL;
               end else if (finish_i) begin
                  tag_q   <= tag_d;
                  ready_q <= 1'b1;
               end
            end
            ST_MUL: begin
               prod_q <= prod_q + (PROD_W'(lane_sum) << (cnt_q*WORD_W));
               cnt_q  <= cnt_q + 1'b1;
               if (cnt_q == LAST_WORD) st_q <= ST_FOLD1;
            end
            ST_FOLD1: begin
               prod_q <= PROD_W'(fold_y);
               st_q   <= ST_FOLD2;
            end
            ST_FOLD2: begin
               h_q  <= fold_y;
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign tag_o   = tag_q;
   assign ready_o = ready_q;
   assign busy_o  = (st_q != ST_IDLE);

   logic [7:0] busy_run;
   always_ff @(posedge clk_i) begin
      if (!rst_ni)     busy_run <= '0;
      else if (busy_o) busy_run <= busy_run + 8'd1;
      else             busy_run <= '0;
   end

   AST_BUSY_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_run <= 8'(SUM_WORDS + 2));                                          // R5
   AST_NEXT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (next_i && !busy_o && !init_i) |=> (busy_o && !ready_o));                // R8
   AST_READY_AFTER_FINISH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (finish_i && !next_i && !busy_o && !init_i) |=> ready_o);                // R7
   AST_FINISH_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && finish_i && !init_i) |=> !ready_o);                           // R6
   AST_TAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && !init_i && !next_i) |=> $stable(tag_o));                     // R8
   AST_INIT_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      init_i |=> (!busy_o && !ready_o));                                       // R10
   AST_FOLD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_FOLD2 && !init_i) |=> (h_q < PRIME + 131'd10));              // R9
endmodule

// File: tb/otmac_engine_test.sv
module otmac_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [127:0] MASK = 128'h0ffffffc_0ffffffc_0ffffffc_0fffffff;

   logic         clk_i = 1'b0;
   logic         rst_ni = 1'b0;
   logic         init_i = 1'b0, next_i = 1'b0, finish_i = 1'b0;
   logic [255:0] key_i = '0;
   logic [127:0] blk_i = '0;
   logic [4:0]   len_i = '0;
   logic [127:0] tag_o;
   logic         ready_o, busy_o;

   int n_checks = 0, n_fails = 0;
   bit done = 0;

   logic [127:0] msg_blk [0:15];
   logic [4:0]   msg_len [0:15];
   int           msg_n;
   logic [255:0] cur_key;

   otmac_engine uut (.*);

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   function automatic logic [263:0] pad_ref(input logic [127:0] b, input logic [4:0] l);
      int n = (l > 16) ? 16 : int'(l);
      logic [263:0] m = '0;
      for (int i = 0; i < n; i++) m[8*i +: 8] = b[8*i +: 8];
      m[8*n] = 1'b1;
      return m;
   endfunction

   function automatic logic [127:0] model_tag(input logic [255:0] k);
      logic [263:0] p  = (264'd1 << 130) - 264'd5;
      logic [263:0] rc = {136'd0, k[127:0] & MASK};
      logic [263:0] h  = '0;
      logic [263:0] t;
      for (int i = 0; i < msg_n; i++) h = ((h + pad_ref(msg_blk[i], msg_len[i])) * rc) % p;
      t = h + {136'd0, k[255:128]};
      return t[127:0];
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_init(input logic [255:0] k);
      @(negedge clk_i); init_i = 1'b1; key_i = k;
      @(negedge clk_i); init_i = 1'b0;
      cur_key = k; msg_n = 0;
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0;
      while (busy_o) begin cyc++; @(negedge clk_i); end
   endtask

   task automatic send_blk(input logic [127:0] b, input logic [4:0] l);
      int cyc;
      @(negedge clk_i); blk_i = b; len_i = l; next_i = 1'b1;
      @(negedge clk_i); next_i = 1'b0;
      msg_blk[msg_n] = b; msg_len[msg_n] = l; msg_n++;
      wait_idle(cyc);
   endtask

   task automatic do_finish(input string req, output logic [127:0] t);
      @(negedge clk_i); finish_i = 1'b1;
      @(negedge clk_i); finish_i = 1'b0;
      chk(req, {127'd0, ready_o}, 128'd1);
      chk(req, tag_o, model_tag(cur_key));
      t = tag_o;
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [127:0] t, t2;
      logic [255:0] k;
      int cyc;
      repeat (3) @(negedge clk_i);
      // R1: reset state
      chk("R1 ready", {127'd0, ready_o}, 128'd0);
      chk("R1 busy", {127'd0, busy_o}, 128'd0);
      chk("R1 tag", tag_o, 128'd0);
      rst_ni = 1'b1;

      // R2/R3: r bits outside the clamp mask ignored -> r = 0, tag = s
      k = {128'h0123456789abcdeffedcba9876543210, 128'hf0000003_f0000003_f0000003_f0000000};
      do_init(k);
      chk("R2 ready after init", {127'd0, ready_o}, 128'd0);
      send_blk(rnd128(), 5'd16);
      send_blk(rnd128(), 5'd7);
      do_finish("R3 zero r", t);
      chk("R3 tag equals s", t, k[255:128]);

      // R5: busy duration, one block
      do_init({rnd128(), rnd128()});
      @(negedge clk_i); blk_i = rnd128(); len_i = 5'd16; next_i = 1'b1;
      @(negedge clk_i); next_i = 1'b0;
      msg_blk[0] = blk_i; msg_len[0] = 5'd16; msg_n = 1;
      chk("R8 ready cleared by next", {127'd0, ready_o}, 128'd0);
      wait_idle(cyc);
      chk("R5 busy cycles", 128'(cyc), 128'd7);
      do_finish("R5 single block", t);

      // R8: tag holds while ready
      repeat (4) @(negedge clk_i);
      chk("R8 tag hold", tag_o, t);
      chk("R8 ready hold", {127'd0, ready_o}, 128'd1);

      // R4: length sweep 1..16 plus oversize
      k = {rnd128(), rnd128()};
      for (int l = 1; l <= 16; l++) begin
         do_init(k);
         send_blk(128'h0f0e0d0c_0b0a0908_07060504_03020100 ^ 128'(l), 5'(l));
         do_finish($sformatf("R4 len %0d", l), t);
      end
      do_init(k);
      send_blk(128'h0f0e0d0c_0b0a0908_07060504_03020110, 5'd20);
      do_finish("R4 oversize", t2);
      chk("R4 oversize equals 16", t2, t);

      // R4: bytes past n ignored
      do_init(k);
      send_blk(128'h00000000_00000000_000000aa_bbccddee, 5'd5);
      do_finish("R4 short a", t);
      do_init(k);
      send_blk(128'h99887766_55443322_110022aa_bbccddee, 5'd5);
      do_finish("R4 short b", t2);
      chk("R4 garbage ignored", t2, t);

      // R3: clamped bits of r do not matter
      k = {rnd128(), 128'hffffffff_ffffffff_ffffffff_ffffffff};
      do_init(k);
      send_blk(rnd128(), 5'd16);
      do_finish("R3 all-ones r", t);
      do_init({k[255:128], MASK});
      send_blk(msg_blk[0], 5'd16);
      do_finish("R3 mask r", t2);
      chk("R3 clamp equivalence", t2, t);

      // R9: r = 1, two all-ones blocks -> accumulator 2^130-2, tag = s + 3
      k = {rnd128(), 128'd1};
      do_init(k);
      send_blk('1, 5'd16);
      send_blk('1, 5'd16);
      do_finish("R9 final subtract", t);
      chk("R9 hand value", t, k[255:128] + 128'd3);
      do_init(k);
      for (int i = 0; i < 6; i++) send_blk('1, 5'd16);
      do_finish("R9 long all-ones", t);

      // R6: strobes during busy dropped
      do_init({rnd128(), rnd128()});
      @(negedge clk_i); blk_i = rnd128(); len_i = 5'd16; next_i = 1'b1;
      @(negedge clk_i);
      msg_blk[0] = blk_i; msg_len[0] = 5'd16; msg_n = 1;
      blk_i = rnd128();
      @(negedge clk_i); next_i = 1'b0; finish_i = 1'b1;
      @(negedge clk_i); finish_i = 1'b0;
      chk("R6 finish dropped", {127'd0, ready_o}, 128'd0);
      wait_idle(cyc);
      do_finish("R6 next dropped", t);

      // R10: init aborts a running update
      do_init({rnd128(), rnd128()});
      @(negedge clk_i); blk_i = rnd128(); len_i = 5'd16; next_i = 1'b1;
      @(negedge clk_i); next_i = 1'b0;
      @(negedge clk_i);
      k = {rnd128(), rnd128()};
      init_i = 1'b1; key_i = k;
      @(negedge clk_i); init_i = 1'b0;
      cur_key = k; msg_n = 0;
      chk("R10 busy dropped", {127'd0, busy_o}, 128'd0);
      send_blk(rnd128(), 5'd11);
      do_finish("R10 new key only", t);

      // R5/R7: random multi-block messages
      for (int m = 0; m < 24; m++) begin
         do_init({rnd128(), rnd128()});
         for (int b = 0; b < 1 + (m % 6); b++)
            send_blk(rnd128(), 5'(1 + ($urandom % 16)));
         do_finish($sformatf("R7 random msg %0d", m), t);
      end

      // R7: empty message
      k = {rnd128(), rnd128()};
      do_init(k);
      do_finish("R7 empty", t);
      chk("R7 empty equals s", t, k[255:128]);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule